// File: doc/BRIEF.md
# Six-Channel Centred Pulse-Width Generator

This block drives six pulse-width outputs from one shared period counter. Each channel is given a start offset and a pulse length, both counted in clock cycles. A controller works these out so that each pulse sits in the middle of the common period. The period length is a parameter, and the default of 4000 cycles gives a 10 kHz rate from a 40 MHz clock. Every output bit comes straight from a flip-flop. All six bits are updated on the same edge as one parallel word, so two channels with the same settings switch together with no skew.

New settings are written with a one-cycle load strobe into a shadow copy. The shadow copy moves into the working copy only at the period boundary, so a pulse is never cut short or stretched by a change in mid-period. A load made in the last cycle of a period goes straight into the working copy and governs the next period.

Each channel runs a small state machine with three states. CH_WAIT means the start offset has not been reached yet. CH_HIGH means the pulse is being emitted, with a remaining-length count. CH_DONE means the output stays low until the period ends. The transitions are:
- start: CH_WAIT to CH_HIGH, when the position equals the offset and the length is non-zero.
- skip: CH_WAIT to CH_DONE, when the position equals the offset and the length is zero.
- expire: CH_HIGH to CH_DONE, when the remaining count is zero.
- restart: any state is treated as CH_WAIT at period position 0.

Top module: `centre_pwm_bank`

## Requirements
- R1: A synchronous reset, active high, clears the period position to 0, clears the output word, and clears the shadow and working settings of every channel. After reset, every output stays low until settings are loaded.
- R2: The period position counts 0, 1, …, PERIOD-1 and then returns to 0. The position is 0 in the first cycle after reset is released. The output word seen after the edge that ends position p reflects position p, so the output lags the position by one cycle. A given channel's pulse repeats every PERIOD cycles.
- R3: Channel k takes its start offset d from `delay_i[k*VAL_W +: VAL_W]` and its length h from `high_i[k*VAL_W +: VAL_W]`. Bit k of the output is 1 exactly for positions p with d <= p < d+h.
- R4: A length of 0 keeps that channel low for the whole period, whatever its offset.
- R5: If d+h is greater than PERIOD, the pulse ends at position PERIOD-1 and does not continue into the next period. An offset of PERIOD or more gives no pulse.
- R6: A load captures all channel settings into the shadow copy. The shadow copy moves into the working copy only when the position goes from PERIOD-1 to 0, so settings are never changed partway through a period. If several loads occur in one period, the last one wins.
- R7: A load made in the cycle at position PERIOD-1 takes effect from position 0 of the very next period.
- R8: Channels loaded with the same offset and length produce identical output bits in every cycle, because all bits are registered together as one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Strobe that captures the setting buses |
| delay_i | input | NUM_CH*VAL_W | Start offset for each channel, packed per channel |
| high_i | input | NUM_CH*VAL_W | Pulse length for each channel, packed per channel |
| pwm_o | output | NUM_CH | Registered pulse outputs, one bit per channel |

## Verification
The sharp collision is a load strobe that falls in the same cycle as the period wrap. At that moment the working copy is being refreshed from the shadow copy while the shadow copy is itself being overwritten. The bench forces this both on purpose and as a side effect of sweeping the load point across the period. It then compares every output bit of the following period against an arithmetic model in which the value just loaded governs. A second overlap is a pulse cut off at the wrap in the same cycle that a new period's pulse starting at offset 0 begins. The bench covers this by sweeping offsets and lengths past the period length, and judges it bit by bit against the model.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic [1:0] {
        CH_WAIT = 2'd0,
        CH_HIGH = 2'd1,
        CH_DONE = 2'd2
    } ch_state_e;

endpackage

// File: rtl/cpwm_period_ctr.sv
module cpwm_period_ctr #(
    parameter int PERIOD = 4000,
    localparam int CTR_W = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CTR_W-1:0] cnt,
    output logic             first,
    output logic             last
);

    localparam logic [CTR_W-1:0] LAST_POS = CTR_W'(PERIOD - 1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == LAST_POS)
            cnt <= '0;
        else
            cnt <= cnt + CTR_W'(1);
    end

    assign first = (cnt == '0);
    assign last  = (cnt == LAST_POS);

endmodule

// File: rtl/cpwm_param_bank.sv
module cpwm_param_bank #(
    parameter int NUM_CH = 6,
    parameter int VAL_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic                    wrap,
    input  logic [NUM_CH*VAL_W-1:0] delay_in,
    input  logic [NUM_CH*VAL_W-1:0] high_in,
    output logic [NUM_CH*VAL_W-1:0] act_d,
    output logic [NUM_CH*VAL_W-1:0] act_h
);

    logic [NUM_CH*VAL_W-1:0] shd_d;
    logic [NUM_CH*VAL_W-1:0] shd_h;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                shd_d[k*VAL_W +: VAL_W] <= '0;
                shd_h[k*VAL_W +: VAL_W] <= '0;
            end else if (load) begin
                shd_d[k*VAL_W +: VAL_W] <= delay_in[k*VAL_W +: VAL_W];
                shd_h[k*VAL_W +: VAL_W] <= high_in[k*VAL_W +: VAL_W];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                act_d[k*VAL_W +: VAL_W] <= '0;
                act_h[k*VAL_W +: VAL_W] <= '0;
            end else if (wrap) begin
                act_d[k*VAL_W +: VAL_W] <= load ? delay_in[k*VAL_W +: VAL_W]
                                                : shd_d[k*VAL_W +: VAL_W];
                act_h[k*VAL_W +: VAL_W] <= load ? high_in[k*VAL_W +: VAL_W]
                                                : shd_h[k*VAL_W +: VAL_W];
            end
        end
    end

endmodule

// File: rtl/cpwm_chan_fsm.sv
module cpwm_chan_fsm
    import cpwm_pkg::*;
#(
    parameter int CTR_W = 12,
    parameter int VAL_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             first,
    input  logic [CTR_W-1:0] cnt,
    input  logic [VAL_W-1:0] dly,
    input  logic [VAL_W-1:0] len,
    output logic             pwm
);

    ch_state_e        st, cur, nxt;
    logic [VAL_W-1:0] rem, rem_n;
    logic [VAL_W-1:0] pos;

    assign pos = VAL_W'(cnt);

    always_comb begin
        cur   = first ? CH_WAIT : st;
        nxt   = cur;
        rem_n = rem;
        unique case (cur)
            CH_WAIT: begin
                if (pos == dly) begin
                    if (len != '0) begin
                        nxt   = CH_HIGH;
                        rem_n = len - VAL_W'(1);
                    end else begin
                        nxt   = CH_DONE;
                    end
                end
            end
            CH_HIGH: begin
                if (rem == '0)
                    nxt = CH_DONE;
                else
                    rem_n = rem - VAL_W'(1);
            end
            CH_DONE: nxt = CH_DONE;
            default: nxt = CH_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= CH_WAIT;
            rem <= '0;
        end else begin
            st  <= nxt;
            rem <= rem_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pwm <= 1'b0;
        else
            pwm <= (nxt == CH_HIGH);
    end

endmodule

// File: rtl/centre_pwm_bank.sv
module centre_pwm_bank #(
    parameter int  NUM_CH = 6,
    parameter int  PERIOD = 4000,
    localparam int VAL_W  = $clog2(PERIOD + 1),
    localparam int CTR_W  = $clog2(PERIOD)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_i,
    input  logic [NUM_CH*VAL_W-1:0] delay_i,
    input  logic [NUM_CH*VAL_W-1:0] high_i,
    output logic [NUM_CH-1:0]       pwm_o
);

    logic [CTR_W-1:0]        cnt;
    logic                    first;
    logic                    last;
    logic [NUM_CH*VAL_W-1:0] act_d;
    logic [NUM_CH*VAL_W-1:0] act_h;

    cpwm_period_ctr #(.PERIOD(PERIOD)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .cnt   (cnt),
        .first (first),
        .last  (last)
    );

    cpwm_param_bank #(.NUM_CH(NUM_CH), .VAL_W(VAL_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .load     (load_i),
        .wrap     (last),
        .delay_in (delay_i),
        .high_in  (high_i),
        .act_d    (act_d),
        .act_h    (act_h)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
        cpwm_chan_fsm #(.CTR_W(CTR_W), .VAL_W(VAL_W)) u_fsm (
            .clk   (clk),
            .rst   (rst),
            .first (first),
            .cnt   (cnt),
            .dly   (act_d[k*VAL_W +: VAL_W]),
            .len   (act_h[k*VAL_W +: VAL_W]),
            .pwm   (pwm_o[k])
        );
    end

endmodule

// File: rtl/cpwm_checker.sv
module cpwm_checker #(
    parameter int  NUM_CH = 6,
    parameter int  PERIOD = 4000,
    localparam int VAL_W  = $clog2(PERIOD + 1),
    localparam int CTR_W  = $clog2(PERIOD)
) (
    input logic                    clk,
    input logic                    rst,
    input logic [CTR_W-1:0]        cnt,
    input logic [NUM_CH*VAL_W-1:0] act_d,
    input logic [NUM_CH*VAL_W-1:0] act_h,
    input logic [NUM_CH-1:0]       pwm_o
);

    localparam logic [CTR_W-1:0] LAST_POS = CTR_W'(PERIOD - 1);

    logic rst_q = 1'b0;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: one edge after a reset edge, position and outputs are zero
    always @(posedge clk) begin
        if (rst_q) begin
            p_reset_clear_r1: assert (pwm_o == '0 && cnt == '0)
                else $error("reset did not clear position/outputs");
        end
    end

    p_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST_POS);

    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt == LAST_POS) |=> (cnt == '0));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt != LAST_POS) |=> (cnt == $past(cnt) + CTR_W'(1)));

    p_hold_mid_r6: assert property (@(posedge clk) disable iff (rst)
        (cnt != LAST_POS) |=> ($stable(act_d) && $stable(act_h)));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ck
        p_zero_len_r4: assert property (@(posedge clk) disable iff (rst)
            (act_h[k*VAL_W +: VAL_W] == '0) |=> !pwm_o[k]);

        p_no_spill_r5: assert property (@(posedge clk) disable iff (rst)
            (cnt == '0 && !(act_d[k*VAL_W +: VAL_W] == '0 &&
                            act_h[k*VAL_W +: VAL_W] != '0)) |=> !pwm_o[k]);
    end

endmodule

bind centre_pwm_bank cpwm_checker #(.NUM_CH(NUM_CH), .PERIOD(PERIOD)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .cnt   (cnt),
    .act_d (act_d),
    .act_h (act_h),
    .pwm_o (pwm_o)
);

// File: tb/tb_centre_pwm_bank.sv
module tb_centre_pwm_bank;

    localparam int NCH = 6;
    localparam int P   = 16;
    localparam int VW  = $clog2(P + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              load_i = 1'b0;
    logic [NCH*VW-1:0] delay_i = '0;
    logic [NCH*VW-1:0] high_i = '0;
    logic [NCH-1:0]    pwm_o;

    int checks = 0;
    int errors = 0;

    int pos;
    int act_d [NCH];
    int act_h [NCH];
    int shd_d [NCH];
    int shd_h [NCH];

    centre_pwm_bank #(.NUM_CH(NCH), .PERIOD(P)) dut (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .delay_i (delay_i),
        .high_i  (high_i),
        .pwm_o   (pwm_o)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [NCH-1:0] act,
                         input logic [NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] model_word(input int p);
        logic [NCH-1:0] w;
        for (int k = 0; k < NCH; k++)
            w[k] = (p >= act_d[k]) && (p < act_d[k] + act_h[k]);
        return w;
    endfunction

    task automatic set_ch(input int k, input int d, input int h);
        delay_i[k*VW +: VW] = VW'(d);
        high_i[k*VW +: VW]  = VW'(h);
    endtask

    task automatic tick(input bit ld, input string tag);
        logic [NCH-1:0] exp;
        load_i = ld;
        @(posedge clk);
        exp = model_word(pos);
        if (pos == P - 1) begin
            for (int k = 0; k < NCH; k++) begin
                act_d[k] = ld ? int'(delay_i[k*VW +: VW]) : shd_d[k];
                act_h[k] = ld ? int'(high_i[k*VW +: VW])  : shd_h[k];
            end
        end
        if (ld) begin
            for (int k = 0; k < NCH; k++) begin
                shd_d[k] = int'(delay_i[k*VW +: VW]);
                shd_h[k] = int'(high_i[k*VW +: VW]);
            end
        end
        pos = (pos + 1) % P;
        @(negedge clk);
        load_i = 1'b0;
        check(tag, pwm_o, exp);
    endtask

    task automatic do_reset(input int n);
        rst = 1'b1;
        repeat (n) @(posedge clk);
        pos = 0;
        for (int k = 0; k < NCH; k++) begin
            act_d[k] = 0; act_h[k] = 0; shd_d[k] = 0; shd_h[k] = 0;
        end
        @(negedge clk);
        rst = 1'b0;
        check("R1", pwm_o, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(2);
        // R1: nothing loaded, outputs stay low for two periods
        for (int i = 0; i < 2 * P; i++) tick(1'b0, "R1");

        // R3 R4 R5 R6 R7 R8: sweep offsets and lengths, load point varies
        for (int d = 0; d <= P + 1; d++) begin
            for (int h = 0; h <= P + 1; h++) begin
                string tag;
                set_ch(0, d, h);
                set_ch(1, d, h);
                set_ch(2, (d + 3) % (P + 2), h);
                set_ch(3, d, (h + 5) % (P + 2));
                set_ch(4, (d * 3) % (P + 2), (h * 7) % (P + 2));
                set_ch(5, P + 1 - d, P + 1 - h);
                while (pos != (d * 5 + h) % P) tick(1'b0, "R6");
                tick(1'b1, (pos == P - 1) ? "R7" : "R6");
                if (h == 0)         tag = "R4";
                else if (d + h > P) tag = "R5";
                else                tag = "R3";
                for (int i = 0; i < 2 * P; i++) begin
                    tick(1'b0, tag);
                    checks++;
                    if (pwm_o[0] !== pwm_o[1]) begin
                        errors++;
                        $display("FAIL R8 actual=%b expected=%b",
                                 pwm_o[1], pwm_o[0]);
                    end
                end
            end
        end

        // R7: load exactly in the last position, then a later load overwrites
        while (pos != P - 1) tick(1'b0, "R7");
        for (int k = 0; k < NCH; k++) set_ch(k, k, 2 + k);
        tick(1'b1, "R7");
        for (int i = 0; i < P; i++) tick(1'b0, "R7");
        // R6: two loads in one period, last wins, neither shows before wrap
        while (pos != 3) tick(1'b0, "R6");
        for (int k = 0; k < NCH; k++) set_ch(k, 1, P);
        tick(1'b1, "R6");
        for (int k = 0; k < NCH; k++) set_ch(k, 2 * k, 3);
        tick(1'b1, "R6");
        for (int i = 0; i < 2 * P; i++) tick(1'b0, "R6");

        // R2: rising edges of channel 0 are exactly P cycles apart
        begin
            int last_rise = -1;
            int n = 0;
            logic prev = pwm_o[0];
            for (int k = 0; k < NCH; k++) set_ch(k, 5, 1);
            tick(1'b1, "R2");
            for (int i = 0; i < 4 * P; i++) begin
                tick(1'b0, "R2");
                if (pwm_o[0] && !prev) begin
                    if (last_rise >= 0) begin
                        checks++;
                        if (n - last_rise != P) begin
                            errors++;
                            $display("FAIL R2 actual=%0d expected=%0d",
                                     n - last_rise, P);
                        end
                    end
                    last_rise = n;
                end
                prev = pwm_o[0];
                n++;
            end
        end

        // R1: reset in mid-period clears everything
        while (pos != 7) tick(1'b0, "R3");
        do_reset(1);
        for (int i = 0; i < 2 * P; i++) tick(1'b0, "R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule